// File: doc/BRIEF.md
# Host Command Mailbox with Latched Event Flags

This block is a byte-wide register file that a host reaches over a plain read/write bus, one byte per 32-bit word. The host stages a parameter byte, then writes an opcode. After a fixed execution delay the block echoes the opcode into a response word, updates its result bytes and steps an acknowledge counter. A host driver reads the counter, writes the opcode, and waits for the counter to move. It then compares the echo against the opcode it sent, and reads the results.

Five event-pulse inputs from neighbouring timecode logic set latched flags. The flags are visible to polling whether or not their interrupt is enabled. An interrupt mask, maintained only through commands, selects which flags drive the interrupt line. Three flags are cleared when the host reads the word that belongs to their source. The two field flags can be cleared only by a flag-acknowledge command. A separate write-only word drops the pending interrupt line until the next event arrives.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the version word reads 0xA2 (type nibble 0xA high, revision nibble 0x2 low). The flags, echo, acknowledge counter, mask and results are zero, and irq_o is low.
- R2: Only accesses with address bits [1:0] equal to zero are decoded. A misaligned read returns 0x00, and a misaligned write has no effect.
- R3: The word map has read-only words and write-only words. Read-only: version 0x00, flags 0x04, echo 0x08, ack 0x0C, mixed source 0x20, LTC source 0x24, VITC source 0x28, and results RES0..RES10 at 0x2C..0x54. Write-only: opcode 0x10, param0 0x14, param1 0x18 (accepted, unused by the present opcodes) and line-release 0x1C. Writes to read-only words are ignored. Reads of write-only or unmapped words return 0x00. Read data appears on bus_rdata_o the cycle after bus_rd_i.
- R4: An opcode write executes EXEC_CYCLES clock edges later. The echo word then holds the opcode if it is 0x01, 0x03, 0x04, 0x05 or 0x48, and 0xFF otherwise. An unknown opcode leaves the mask, flags and results untouched.
- R5: The acknowledge counter rises by exactly one for every executed command, known or unknown, and wraps from 0xFF to 0x00.
- R6: While a command is executing, opcode writes are ignored. The parameter byte is captured when the opcode is accepted, so later param0 writes do not alter the running command.
- R7: Opcode 0x03 loads the mask from param0, 0x04 ORs param0 into it, and 0x05 clears the param0 bits from it. Each writes the resulting mask to RES0.
- R8: Event input bits 0..4 set flag bits 0x01 (mixed), 0x04 (LTC), 0x08 (VITC), 0x40 (odd field) and 0x80 (even field). Flags latch regardless of the mask, and flag bits 1, 4 and 5 always read zero.
- R9: Reading the mixed, LTC or VITC source word returns that flag's bit as it stood before the read, and clears it. No read clears the field flags.
- R10: Opcode 0x48 clears every flag whose bit is set in param0.
- R11: Opcode 0x01 returns the mask, flags, line hold and all results to zero. It still echoes 0x01 and steps the counter.
- R12: irq_o is high when any flag ANDed with the mask is set. A write to the line-release word holds irq_o low until the next event pulse.
- R13: An event pulse in the same cycle as a clear of its flag, from a read, an acknowledge or a reset command, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| src_evt_i | input | 5 | Event pulses: mixed, LTC, VITC, odd field, even field |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with EXEC_CYCLES set to 3 rather than the default 2. This gives room to read the acknowledge counter on every edge of the execution window and pin down the exact edge it moves on. The longer window also gives time to land a second opcode and a fresh parameter write while the first command is still running. The default ADDR_W of 7 holds the whole word map, so misaligned and unmapped addresses are reachable without aliasing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned NSRC  = 5;
   localparam int unsigned NRES  = 11;
   localparam int unsigned NWORD = 22;

   localparam int unsigned W_VERSION  = 0;
   localparam int unsigned W_FLAGS    = 1;
   localparam int unsigned W_ECHO     = 2;
   localparam int unsigned W_ACK      = 3;
   localparam int unsigned W_OPCODE   = 4;
   localparam int unsigned W_PARAM0   = 5;
   localparam int unsigned W_PARAM1   = 6;
   localparam int unsigned W_LINEREL  = 7;
   localparam int unsigned W_SRC_BASE = 8;
   localparam int unsigned W_RES0     = 11;

   localparam logic [7:0] OP_RESET     = 8'h01;
   localparam logic [7:0] OP_MASK_LOAD = 8'h03;
   localparam logic [7:0] OP_MASK_SET  = 8'h04;
   localparam logic [7:0] OP_MASK_CLR  = 8'h05;
   localparam logic [7:0] OP_FLAG_ACK  = 8'h48;
   localparam logic [7:0] RESP_UNKNOWN = 8'hFF;

   // flag bit position of each event source; neighbours decode these
   function automatic int unsigned src_bit(input int unsigned s);
      case (s)
         0: return 0;
         1: return 2;
         2: return 3;
         3: return 6;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/mbx_flags.sv
module mbx_flags
   import mbx_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] evt_i,
   input  logic [2:0]      rdclr_i,
   input  logic            cmdclr_en_i,
   input  logic [7:0]      cmdclr_bits_i,
   input  logic            wipe_i,
   input  logic [7:0]      mask_i,
   input  logic            linerel_i,
   output logic [7:0]      flags_o,
   output logic            irq_o
);
   logic [NSRC-1:0] fbit_q;
   logic            hold_q;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int unsigned B = src_bit(s);
      logic clr_rd;
      if (s < 3) begin : g_rdclr
         assign clr_rd = rdclr_i[s];
      end else begin : g_cmdonly
         assign clr_rd = 1'b0;
      end

      // set beats every clear source
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                       fbit_q[s] <= 1'b0;
         else if (evt_i[s])                                 fbit_q[s] <= 1'b1;
         else if (wipe_i || clr_rd ||
                  (cmdclr_en_i && cmdclr_bits_i[B]))        fbit_q[s] <= 1'b0;
      end

      p_flag_set_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
         evt_i[s] |=> fbit_q[s]);

      if (s >= 3) begin : g_field_chk
         p_field_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fbit_q[s] && !wipe_i && !(cmdclr_en_i && cmdclr_bits_i[B])) |=> fbit_q[s]);
      end
   end

   always_comb begin
      flags_o = '0;
      for (int unsigned s = 0; s < NSRC; s++) flags_o[src_bit(s)] = fbit_q[s];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hold_q <= 1'b0;
      else if (|evt_i)    hold_q <= 1'b0;
      else if (wipe_i)    hold_q <= 1'b0;
      else if (linerel_i) hold_q <= 1'b1;
   end

   assign irq_o = (|(flags_o & mask_i)) && !hold_q;

   p_line_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (linerel_i && !(|evt_i)) |=> !irq_o);
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
   import mbx_pkg::*;
#(
   parameter int unsigned EXEC_CYCLES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       op_wr_i,
   input  logic       p0_wr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] echo_o,
   output logic [7:0] ack_o,
   output logic [7:0] mask_o,
   output logic [7:0] res_o [NRES],
   output logic       flag_clr_en_o,
   output logic [7:0] flag_clr_bits_o,
   output logic       wipe_o
);
   localparam int unsigned CW = $clog2(EXEC_CYCLES + 1);

   if (EXEC_CYCLES < 1) begin : g_bad_exec
      $error("mbx_seq: EXEC_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [7:0]    op_q, p0_q, snap_q, mask_q, mask_n, echo_q, ack_q;
   logic          busy, fire, known, mask_res;

   assign busy = (cnt_q != '0);
   assign fire = (cnt_q == CW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      p0_q <= '0;
      else if (p0_wr_i) p0_q <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         op_q   <= '0;
         snap_q <= '0;
      end else if (op_wr_i && !busy) begin
         cnt_q  <= CW'(EXEC_CYCLES);
         op_q   <= wdata_i;
         snap_q <= p0_q;
      end else if (busy) begin
         cnt_q  <= cnt_q - CW'(1);
      end
   end

   always_comb begin
      known    = 1'b1;
      mask_n   = mask_q;
      mask_res = 1'b0;
      case (op_q)
         OP_RESET:     mask_n = '0;
         OP_MASK_LOAD: begin mask_n = snap_q;            mask_res = 1'b1; end
         OP_MASK_SET:  begin mask_n = mask_q | snap_q;   mask_res = 1'b1; end
         OP_MASK_CLR:  begin mask_n = mask_q & ~snap_q;  mask_res = 1'b1; end
         OP_FLAG_ACK:  ;
         default:      known = 1'b0;
      endcase
   end

   assign wipe_o          = fire && (op_q == OP_RESET);
   assign flag_clr_en_o   = fire && (op_q == OP_FLAG_ACK);
   assign flag_clr_bits_o = snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         echo_q <= '0;
         ack_q  <= '0;
         mask_q <= '0;
      end else if (fire) begin
         echo_q <= known ? op_q : RESP_UNKNOWN;
         ack_q  <= ack_q + 8'd1;
         mask_q <= mask_n;
      end
   end

   for (genvar i = 0; i < NRES; i++) begin : g_res
      logic [7:0] r_q;
      if (i == 0) begin : g_mask_slot
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                r_q <= '0;
            else if (wipe_o)            r_q <= '0;
            else if (fire && mask_res)  r_q <= mask_n;
         end
      end else begin : g_plain_slot
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     r_q <= '0;
            else if (wipe_o) r_q <= '0;
         end
      end
      assign res_o[i] = r_q;
   end

   assign echo_o = echo_q;
   assign ack_o  = ack_q;
   assign mask_o = mask_q;

   p_ack_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_q != $past(ack_q)) |-> (ack_q == $past(ack_q) + 8'd1));
   p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> $stable(op_q) && $stable(snap_q));
   p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire |=> $stable(mask_q));
   p_echo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire |=> (echo_q == $past(op_q)) || (echo_q == RESP_UNKNOWN));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned EXEC_CYCLES = 2,
   parameter logic [3:0]  VER_TYPE    = 4'hA,
   parameter logic [3:0]  VER_REV     = 4'h2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   input  logic [NSRC-1:0]   src_evt_i,
   output logic              irq_o
);
   localparam int unsigned IW = ADDR_W - 2;

   if ((NWORD * 4) > (1 << ADDR_W)) begin : g_bad_addr
      $error("cmd_mailbox: ADDR_W too small for the word map");
   end

   logic [IW-1:0] widx;
   logic          aligned, wr_ok, rd_ok;
   logic [7:0]    echo, ack, mask, flags, rd_mux, rdata_q;
   logic [7:0]    res [NRES];
   logic          flag_clr_en, wipe;
   logic [7:0]    flag_clr_bits;
   logic [2:0]    rdclr;

   assign widx    = bus_addr_i[ADDR_W-1:2];
   assign aligned = (bus_addr_i[1:0] == 2'b00);
   assign wr_ok   = bus_wr_i && aligned;
   assign rd_ok   = bus_rd_i && aligned;

   for (genvar k = 0; k < 3; k++) begin : g_rdclr
      assign rdclr[k] = rd_ok && (widx == IW'(W_SRC_BASE + k));
   end

   mbx_seq #(.EXEC_CYCLES(EXEC_CYCLES)) i_seq (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .op_wr_i         (wr_ok && (widx == IW'(W_OPCODE))),
      .p0_wr_i         (wr_ok && (widx == IW'(W_PARAM0))),
      .wdata_i         (bus_wdata_i),
      .echo_o          (echo),
      .ack_o           (ack),
      .mask_o          (mask),
      .res_o           (res),
      .flag_clr_en_o   (flag_clr_en),
      .flag_clr_bits_o (flag_clr_bits),
      .wipe_o          (wipe)
   );

   mbx_flags i_flags (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .evt_i         (src_evt_i),
      .rdclr_i       (rdclr),
      .cmdclr_en_i   (flag_clr_en),
      .cmdclr_bits_i (flag_clr_bits),
      .wipe_i        (wipe),
      .mask_i        (mask),
      .linerel_i     (wr_ok && (widx == IW'(W_LINEREL))),
      .flags_o       (flags),
      .irq_o         (irq_o)
   );

   always_comb begin
      rd_mux = '0;
      if (aligned) begin
         if (widx == IW'(W_VERSION)) rd_mux = {VER_TYPE, VER_REV};
         if (widx == IW'(W_FLAGS))   rd_mux = flags;
         if (widx == IW'(W_ECHO))    rd_mux = echo;
         if (widx == IW'(W_ACK))     rd_mux = ack;
         for (int unsigned k = 0; k < 3; k++)
            if (widx == IW'(W_SRC_BASE + k)) rd_mux = flags & (8'd1 << src_bit(k));
         for (int unsigned i = 0; i < NRES; i++)
            if (widx == IW'(W_RES0 + i)) rd_mux = res[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_mux;
   end

   assign bus_rdata_o = rdata_q;

   p_misaligned_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && !aligned) |=> (bus_rdata_o == 8'h00));
   p_version_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok && widx == IW'(W_VERSION)) |=> (bus_rdata_o == {VER_TYPE, VER_REV}));
endmodule

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;
   localparam int unsigned AW = 7;
   localparam int unsigned E  = 3;
   localparam int W_VERSION = 0, W_FLAGS = 1, W_ECHO = 2, W_ACK = 3, W_OPCODE = 4,
                  W_PARAM0 = 5, W_LINEREL = 7, W_MIX = 8, W_LTC = 9, W_VITC = 10,
                  W_RES0 = 11, W_RES1 = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [4:0]    evt = '0;
   logic          irq;

   int compared = 0, mismatched = 0;
   logic [7:0] exp_ack = 8'h00;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       rd_seen = 1'b0;

   always #4 clk = ~clk;

   cmd_mailbox #(.ADDR_W(AW), .EXEC_CYCLES(E)) i_cmd_mailbox (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
      .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .src_evt_i(evt), .irq_o(irq));

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: compares each read result the cycle after its strobe
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic wr(input int w, input logic [7:0] d, input int off = 0);
      bus_addr = AW'(w * 4 + off); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input int w, input logic [7:0] exp, input string tag, input int off = 0);
      bus_addr = AW'(w * 4 + off); bus_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] op, input logic [7:0] p0);
      wr(W_PARAM0, p0); wr(W_OPCODE, op); exp_ack = exp_ack + 8'd1; idle(E);
   endtask

   task automatic pulse(input int s);
      evt = 5'(1 << s); @(negedge clk); evt = '0;
   endtask

   initial begin : watchdog
      #(8 * 100000);
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      idle(3); rst_n = 1'b1; idle(1);
      // R1 reset state
      rd(W_VERSION, 8'hA2, "R1 version");
      rd(W_FLAGS, 8'h00, "R1 flags");
      rd(W_ECHO, 8'h00, "R1 echo");
      rd(W_ACK, 8'h00, "R1 ack");
      check({7'd0, irq}, 8'h00, "R1 irq");
      // R2 misaligned
      rd(W_VERSION, 8'h00, "R2 misaligned read", 1);
      wr(W_OPCODE, 8'h03, 2); idle(E + 1);
      rd(W_ACK, 8'h00, "R2 misaligned write");
      // R3 direction
      wr(W_ACK, 8'h55);
      rd(W_ACK, 8'h00, "R3 write to read-only");
      rd(W_OPCODE, 8'h00, "R3 read write-only opcode");
      rd(W_PARAM0, 8'h00, "R3 read write-only param");
      // R4 latency / R7 load
      wr(W_PARAM0, 8'h4C); wr(W_OPCODE, 8'h03);
      for (int i = 0; i < E; i++) rd(W_ACK, 8'h00, "R4 ack before exec edge");
      exp_ack = 8'h01;
      rd(W_ACK, exp_ack, "R4 ack after exec edge");
      rd(W_ECHO, 8'h03, "R4 echo");
      rd(W_RES0, 8'h4C, "R7 mask load");
      // R6 busy ignore and parameter snapshot
      wr(W_PARAM0, 8'h01); wr(W_OPCODE, 8'h04); wr(W_OPCODE, 8'h05); wr(W_PARAM0, 8'hFF);
      exp_ack = exp_ack + 8'd1; idle(E);
      rd(W_ECHO, 8'h04, "R6 echo of first opcode");
      rd(W_ACK, exp_ack, "R6 single ack");
      rd(W_RES0, 8'h4D, "R6 snapshot param");
      // R7 clear bits
      cmd(8'h05, 8'h08);
      rd(W_RES0, 8'h45, "R7 mask clear");
      rd(W_ECHO, 8'h05, "R7 echo");
      // R4 unknown
      cmd(8'h77, 8'h00);
      rd(W_ECHO, 8'hFF, "R4 unknown echo");
      rd(W_ACK, exp_ack, "R5 ack on unknown");
      rd(W_RES0, 8'h45, "R4 unknown keeps results");
      rd(W_RES1, 8'h00, "R4 other result");
      // R8 / R9 / R12 LTC
      pulse(1);
      check({7'd0, irq}, 8'h01, "R12 irq on masked flag");
      rd(W_FLAGS, 8'h04, "R8 LTC flag bit");
      rd(W_LTC, 8'h04, "R9 LTC read value");
      rd(W_FLAGS, 8'h00, "R9 LTC cleared by read");
      check({7'd0, irq}, 8'h00, "R9 irq drops");
      // R12 line release, R9 field not cleared by read
      pulse(3);
      check({7'd0, irq}, 8'h01, "R12 irq odd field");
      wr(W_LINEREL, 8'h00);
      check({7'd0, irq}, 8'h00, "R12 line released");
      rd(W_FLAGS, 8'h40, "R12 flag kept after release");
      rd(W_MIX, 8'h00, "R9 mixed word read");
      rd(W_FLAGS, 8'h40, "R9 field flag survives read");
      check({7'd0, irq}, 8'h00, "R12 still held");
      pulse(0);
      check({7'd0, irq}, 8'h01, "R12 new event reasserts");
      // R8 unmasked latch
      pulse(4);
      rd(W_FLAGS, 8'hC1, "R8 unmasked even field latched");
      // R10 flag ack command
      cmd(8'h48, 8'h40);
      rd(W_FLAGS, 8'h81, "R10 command clear");
      rd(W_ECHO, 8'h48, "R10 echo");
      rd(W_MIX, 8'h01, "R9 mixed read value");
      rd(W_FLAGS, 8'h80, "R9 mixed cleared");
      check({7'd0, irq}, 8'h00, "R12 unmasked flag no irq");
      // R13 set beats read clear
      evt = 5'b00100; bus_addr = AW'(W_VITC * 4); bus_rd = 1'b1;
      exp_q.push_back(8'h00); tag_q.push_back("R13 VITC read before set");
      @(negedge clk); bus_rd = 1'b0; evt = '0;
      rd(W_FLAGS, 8'h88, "R13 set wins");
      // R11 reset command
      cmd(8'h01, 8'h00);
      rd(W_FLAGS, 8'h00, "R11 flags wiped");
      rd(W_RES0, 8'h00, "R11 results wiped");
      rd(W_ECHO, 8'h01, "R11 echo");
      rd(W_ACK, exp_ack, "R11 ack");
      check({7'd0, irq}, 8'h00, "R11 irq low");
      cmd(8'h04, 8'h00);
      rd(W_RES0, 8'h00, "R11 mask zero");
      pulse(1);
      check({7'd0, irq}, 8'h00, "R11 zero mask blocks irq");
      // R5 wrap
      while (exp_ack != 8'hFF) cmd(8'h77, 8'h00);
      rd(W_ACK, 8'hFF, "R5 ack at top");
      cmd(8'h77, 8'h00);
      rd(W_ACK, 8'h00, "R5 ack wraps");
      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule